// File: doc/BRIEF.md
# Floating-Point Register Block-Move Sequencer

This block moves a selected group of the eight 96-bit floating-point registers to or from memory, one register per step. A start pulse supplies a direction, an addressing-mode flag (predecrement or postincrement) and a register mask. The mask comes either from a static field or from the low byte of one of eight data registers. The block then walks the mask.

For each selected register it issues one 96-bit memory request, carried as three 32-bit beats, and holds the request until the memory answers with done or fault. Registers whose mask bit is clear cost no cycles. The first fault ends the sequence and reports which register failed.

The block does no address arithmetic and no format conversion. Data moves bit for bit between the register-file port and the memory port.

Top module: `fpr_block_mover`

## Requirements
- R1: With `to_mem_i`=1 each selected register is read (`rf_rd_o`) and then written to memory (`mem_we_o`=1). With `to_mem_i`=0 memory is read (`mem_we_o`=0) and the data is written to the register (`rf_wr_o`). Registers that are not selected are never written.
- R2: With `dynamic_i`=1 the mask is bits [8*s+7:8*s] of `dreg_low_i`, where s is `dreg_sel_i`. With `dynamic_i`=0 the mask is `static_mask_i`.
- R3: The mask is scanned from bit 7 down to bit 0. With `predec_i`=1, mask bit k selects register k, so registers are visited in descending index order.
- R4: With `predec_i`=0, mask bit k selects register 7-k, so registers are visited in ascending index order.
- R5: The 96 data bits pass unchanged. Beat b occupies bits [32*b+31:32*b] of `mem_wdata_o`, `mem_rdata_i`, `rf_rdata_i` and `rf_wdata_o`.
- R6: Clear mask bits take zero cycles. With a memory that answers in L cycles, a run stays busy for exactly n*(L+2) cycles for n selected registers, whatever the positions of the selected bits.
- R7: An all-zero mask raises `done_o` for one cycle, in the cycle after the start edge. It issues no request and never asserts `busy_o`.
- R8: A `mem_fault_i` answer ends the run in the next cycle. That cycle has `done_o`=1 and `fault_o`=1, `fault_idx_o` names the faulting register, and no further request is made.
- R9: `busy_o` is high from the cycle after an accepted start until `done_o` rises. A start seen while busy is ignored.
- R10: After reset `busy_o`, `done_o`, `fault_o`, `mem_req_o`, `rf_rd_o` and `rf_wr_o` are low.
- R11: A request holds its register index, direction and write data stable until done or fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken when idle |
| to_mem_i | input | 1 | 1: registers to memory, 0: memory to registers |
| predec_i | input | 1 | 1: predecrement addressing, 0: postincrement |
| dynamic_i | input | 1 | 1: mask taken from a data register |
| dreg_sel_i | input | 3 | Data register chosen in dynamic mode |
| static_mask_i | input | 8 | Mask used in static mode |
| dreg_low_i | input | 64 | Low bytes of the eight data registers, register s at [8s+7:8s] |
| rf_idx_o | output | 3 | Register index of the current step |
| rf_rd_o | output | 1 | Register read strobe |
| rf_rdata_i | input | 96 | Register read data, valid while `rf_rd_o` is high |
| rf_wr_o | output | 1 | Register write strobe |
| rf_wdata_o | output | 96 | Register write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_wdata_o | output | 96 | Memory write data |
| mem_rdata_i | input | 96 | Memory read data, valid with `mem_done_i` |
| mem_done_i | input | 1 | Request completed |
| mem_fault_i | input | 1 | Request faulted |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fault_o | output | 1 | One-cycle pulse with `done_o` when the run faulted |
| fault_idx_o | output | 3 | Register that faulted |

## Verification
The mask 0xA5 is run in both addressing modes. Its scattered bits separate the descending from the ascending order and show that bit 7 maps to register 7 in one mode and to register 0 in the other. Reads from memory with latency check that only selected registers change and that the beats arrive in place. A dynamic mask chosen against a full static mask shows which source was used. Masks 0x81 and 0xC0 have equal population but different gaps, and they must take equal busy time. An empty mask, a fault on the second step, and a restart pulse mid-run cover the early-exit and ignore paths.

// File: rtl/fmv_pkg.sv
package fmv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_WAIT  = 2'd2,
        ST_STORE = 2'd3
    } fmv_state_e;

    typedef struct packed {
        logic to_mem;
        logic predec;
    } fmv_mode_t;

    function automatic logic any_set8(input logic [7:0] v);
        return |v;
    endfunction

endpackage

// File: rtl/fmv_mask_src.sv
module fmv_mask_src #(
    parameter int NUM_REGS = 8,
    parameter int DREG_CNT = 8,
    localparam int SEL_W   = $clog2(DREG_CNT)
) (
    input  logic                         dynamic_i,
    input  logic [SEL_W-1:0]             sel_i,
    input  logic [NUM_REGS-1:0]          static_i,
    input  logic [DREG_CNT*NUM_REGS-1:0] dreg_low_i,
    output logic [NUM_REGS-1:0]          mask_o,
    output logic                         nonzero_o
);
    logic [NUM_REGS-1:0] dbytes [DREG_CNT];

    for (genvar g = 0; g < DREG_CNT; g++) begin : g_unpack
        assign dbytes[g] = dreg_low_i[g*NUM_REGS +: NUM_REGS];
    end

    always_comb begin
        mask_o    = dynamic_i ? dbytes[sel_i] : static_i;
        nonzero_o = |mask_o;
    end
endmodule

// File: rtl/fmv_step_pick.sv
module fmv_step_pick #(
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] pend_i,
    input  logic                predec_i,
    output logic                found_o,
    output logic [IDX_W-1:0]    bit_pos_o,
    output logic [IDX_W-1:0]    reg_idx_o,
    output logic [NUM_REGS-1:0] pend_next_o
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_REGS - 1);

    always_comb begin
        bit_pos_o = '0;
        found_o   = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (pend_i[i]) begin
                bit_pos_o = IDX_W'(i);
                found_o   = 1'b1;
            end
        end
        reg_idx_o   = predec_i ? bit_pos_o : (TOP - bit_pos_o);
        pend_next_o = pend_i & ~(NUM_REGS'(1) << bit_pos_o);
    end
endmodule

// File: rtl/fmv_beat_buf.sv
module fmv_beat_buf #(
    parameter int WORD_W = 32,
    parameter int BEATS  = 3,
    localparam int DW    = WORD_W * BEATS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o
);
    for (genvar b = 0; b < BEATS; b++) begin : g_beat
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst)         word_q <= '0;
            else if (load_i) word_q <= data_i[b*WORD_W +: WORD_W];
        end
        assign data_o[b*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/fpr_block_mover.sv
module fpr_block_mover
    import fmv_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DREG_CNT = 8,
    parameter int WORD_W   = 32,
    parameter int BEATS    = 3,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int SEL_W   = $clog2(DREG_CNT),
    localparam int DW      = WORD_W * BEATS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic                         to_mem_i,
    input  logic                         predec_i,
    input  logic                         dynamic_i,
    input  logic [SEL_W-1:0]             dreg_sel_i,
    input  logic [NUM_REGS-1:0]          static_mask_i,
    input  logic [DREG_CNT*NUM_REGS-1:0] dreg_low_i,
    output logic [IDX_W-1:0]             rf_idx_o,
    output logic                         rf_rd_o,
    input  logic [DW-1:0]                rf_rdata_i,
    output logic                         rf_wr_o,
    output logic [DW-1:0]                rf_wdata_o,
    output logic                         mem_req_o,
    output logic                         mem_we_o,
    output logic [DW-1:0]                mem_wdata_o,
    input  logic [DW-1:0]                mem_rdata_i,
    input  logic                         mem_done_i,
    input  logic                         mem_fault_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         fault_o,
    output logic [IDX_W-1:0]             fault_idx_o
);
    fmv_state_e          state_q;
    fmv_mode_t           mode_q;
    logic [NUM_REGS-1:0] pend_q;

    logic [NUM_REGS-1:0] sel_mask;
    logic                sel_nonzero;
    logic                pick_found;
    logic [IDX_W-1:0]    pick_bit;
    logic [IDX_W-1:0]    pick_idx;
    logic [NUM_REGS-1:0] pend_next;
    logic                buf_load;
    logic [DW-1:0]       buf_in;
    logic [DW-1:0]       buf_q;

    fmv_mask_src #(.NUM_REGS(NUM_REGS), .DREG_CNT(DREG_CNT)) u_mask (
        .dynamic_i (dynamic_i),
        .sel_i     (dreg_sel_i),
        .static_i  (static_mask_i),
        .dreg_low_i(dreg_low_i),
        .mask_o    (sel_mask),
        .nonzero_o (sel_nonzero)
    );

    fmv_step_pick #(.NUM_REGS(NUM_REGS)) u_pick (
        .pend_i     (pend_q),
        .predec_i   (mode_q.predec),
        .found_o    (pick_found),
        .bit_pos_o  (pick_bit),
        .reg_idx_o  (pick_idx),
        .pend_next_o(pend_next)
    );

    // Register read fills the buffer in LOAD; memory read fills it on done.
    assign buf_load = (state_q == ST_LOAD) ||
                      (state_q == ST_WAIT && mem_done_i && !mem_fault_i && !mode_q.to_mem);
    assign buf_in   = (state_q == ST_LOAD) ? rf_rdata_i : mem_rdata_i;

    fmv_beat_buf #(.WORD_W(WORD_W), .BEATS(BEATS)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .load_i(buf_load),
        .data_i(buf_in),
        .data_o(buf_q)
    );

    assign busy_o      = (state_q != ST_IDLE);
    assign rf_idx_o    = pick_idx;
    assign rf_rd_o     = (state_q == ST_LOAD);
    assign rf_wr_o     = (state_q == ST_STORE);
    assign rf_wdata_o  = buf_q;
    assign mem_req_o   = (state_q == ST_WAIT);
    assign mem_we_o    = (state_q == ST_WAIT) && mode_q.to_mem;
    assign mem_wdata_o = buf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            mode_q      <= '0;
            pend_q      <= '0;
            done_o      <= 1'b0;
            fault_o     <= 1'b0;
            fault_idx_o <= '0;
        end else begin
            done_o  <= 1'b0;
            fault_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (sel_nonzero) begin
                            pend_q        <= sel_mask;
                            mode_q.to_mem <= to_mem_i;
                            mode_q.predec <= predec_i;
                            state_q       <= to_mem_i ? ST_LOAD : ST_WAIT;
                        end else begin
                            done_o <= 1'b1;
                        end
                    end
                end
                ST_LOAD: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_fault_i) begin
                        state_q     <= ST_IDLE;
                        pend_q      <= '0;
                        done_o      <= 1'b1;
                        fault_o     <= 1'b1;
                        fault_idx_o <= pick_idx;
                    end else if (mem_done_i) begin
                        if (mode_q.to_mem) begin
                            pend_q <= pend_next;
                            if (|pend_next) begin
                                state_q <= ST_LOAD;
                            end else begin
                                state_q <= ST_IDLE;
                                done_o  <= 1'b1;
                            end
                        end else begin
                            state_q <= ST_STORE;
                        end
                    end
                end
                ST_STORE: begin
                    pend_q <= pend_next;
                    if (|pend_next) begin
                        state_q <= ST_WAIT;
                    end else begin
                        state_q <= ST_IDLE;
                        done_o  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && sel_nonzero) |=> busy_o);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_done_i && !mem_fault_i) |=>
            (mem_req_o && $stable(rf_idx_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R8
    fault_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && mem_fault_i) |=> (done_o && fault_o && !busy_o && !mem_req_o));

    // R1
    dir_chk: assert property (@(posedge clk) disable iff (rst)
        rf_rd_o |=> (mem_req_o && mem_we_o));

    // R6
    step_valid_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> pick_found);

    // R7
    empty_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !sel_nonzero) |=> (done_o && !busy_o && !fault_o));
endmodule

// File: tb/fpr_block_mover_bench.sv
module fpr_block_mover_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, to_mem_i = 1'b0, predec_i = 1'b0, dynamic_i = 1'b0;
    logic [2:0]  dreg_sel_i = '0;
    logic [7:0]  static_mask_i = '0;
    logic [63:0] dreg_low_i = '0;
    logic [2:0]  rf_idx_o, fault_idx_o;
    logic        rf_rd_o, rf_wr_o, mem_req_o, mem_we_o, busy_o, done_o, fault_o;
    logic [95:0] rf_rdata_i, rf_wdata_o, mem_wdata_o;
    logic [95:0] mem_rdata_i = '0;
    logic        mem_done_i = 1'b0, mem_fault_i = 1'b0;

    always #2 clk = ~clk;

    fpr_block_mover u_fpr_block_mover (.*);

    int total = 0, bad = 0, cycles = 0;
    logic [95:0] rf_mem [8];
    assign rf_rdata_i = rf_mem[rf_idx_o];

    int lat = 0, fault_at = -1, wcnt = 0, n_xfer = 0, n_req_end = 0;
    logic [2:0]  log_idx [16];
    logic        log_we  [16];
    logic [95:0] log_dat [16];

    function automatic logic [95:0] rf_init(input int i);
        return {32'h3000_0000 + i, 32'h2000_0000 + i, 32'h1000_0000 + i};
    endfunction
    function automatic logic [95:0] rd_pat(input int n);
        return {32'hC000_0000 + n, 32'hB000_0000 + n, 32'hA000_0000 + n};
    endfunction

    // memory and register-file model, evaluated mid-cycle
    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            for (int i = 0; i < 8; i++) rf_mem[i] <= rf_init(i);
            mem_done_i <= 1'b0; mem_fault_i <= 1'b0; wcnt = 0;
        end else begin
            if (rf_wr_o) rf_mem[rf_idx_o] <= rf_wdata_o;
            if (mem_req_o) begin
                if (wcnt >= lat) begin
                    wcnt = 0;
                    if (n_req_end == fault_at) begin
                        mem_fault_i <= 1'b1; mem_done_i <= 1'b0;
                    end else begin
                        mem_fault_i <= 1'b0; mem_done_i <= 1'b1;
                        mem_rdata_i <= rd_pat(n_xfer);
                        if (n_xfer < 16) begin
                            log_idx[n_xfer] = rf_idx_o;
                            log_we[n_xfer]  = mem_we_o;
                            log_dat[n_xfer] = mem_wdata_o;
                        end
                        n_xfer++;
                    end
                    n_req_end++;
                end else begin
                    wcnt++;
                    mem_done_i <= 1'b0; mem_fault_i <= 1'b0;
                end
            end else begin
                wcnt = 0;
                mem_done_i <= 1'b0; mem_fault_i <= 1'b0;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    int busy_cnt, to_done;
    logic saw_fault;
    logic [2:0] fidx;

    task automatic run(input logic [7:0] mask, input logic tm, input logic pd, input logic dyn,
                       input logic [2:0] sel, input int l, input int fa, input int restart_at);
        lat = l; fault_at = fa; n_xfer = 0; n_req_end = 0;
        busy_cnt = 0; to_done = 0; saw_fault = 1'b0; fidx = '0;
        static_mask_i = mask; to_mem_i = tm; predec_i = pd; dynamic_i = dyn; dreg_sel_i = sel;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 1; c < 3000; c++) begin
            to_done = c;
            if (c == restart_at) begin
                start_i = 1'b1; static_mask_i = 8'hFF; to_mem_i = ~tm;
            end else if (c == restart_at + 1) begin
                start_i = 1'b0; static_mask_i = mask; to_mem_i = tm;
            end
            if (busy_o) busy_cnt++;
            if (done_o) begin
                saw_fault = fault_o; fidx = fault_idx_o;
                break;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(done_o, "run completion", 96'(done_o), 96'd1);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o && !fault_o, "R10 status", {busy_o, done_o, fault_o}, 0);
        chk(!mem_req_o && !rf_rd_o && !rf_wr_o, "R10 strobes", {mem_req_o, rf_rd_o, rf_wr_o}, 0);
    endtask

    task automatic t_predec_store();
        logic [2:0] e [4] = '{3'd7, 3'd5, 3'd2, 3'd0};
        run(8'hA5, 1'b1, 1'b1, 1'b0, 3'd0, 0, -1, 0);
        chk(n_xfer == 4, "R3 count", 96'(n_xfer), 96'd4);
        for (int i = 0; i < 4; i++) begin
            chk(log_idx[i] == e[i], "R3 order", 96'(log_idx[i]), 96'(e[i]));
            chk(log_we[i], "R1 write dir", 96'(log_we[i]), 96'd1);
            chk(log_dat[i] == rf_init(int'(e[i])), "R5 beats", log_dat[i], rf_init(int'(e[i])));
        end
        chk(busy_cnt == 8, "R6 busy cycles", 96'(busy_cnt), 96'd8);
    endtask

    task automatic t_postinc_store();
        logic [2:0] e [4] = '{3'd0, 3'd2, 3'd5, 3'd7};
        run(8'hA5, 1'b1, 1'b0, 1'b0, 3'd0, 1, -1, 0);
        for (int i = 0; i < 4; i++)
            chk(log_idx[i] == e[i], "R4 order", 96'(log_idx[i]), 96'(e[i]));
        chk(busy_cnt == 12, "R6 busy latency1", 96'(busy_cnt), 96'd12);
    endtask

    task automatic t_load();
        run(8'h81, 1'b0, 1'b0, 1'b0, 3'd0, 2, -1, 0);
        chk(n_xfer == 2 && !log_we[0] && !log_we[1], "R1 read dir", 96'(n_xfer), 96'd2);
        chk(rf_mem[0] == rd_pat(0), "R5 reg0 load", rf_mem[0], rd_pat(0));
        chk(rf_mem[7] == rd_pat(1), "R5 reg7 load", rf_mem[7], rd_pat(1));
        chk(rf_mem[3] == rf_init(3), "R1 unselected untouched", rf_mem[3], rf_init(3));
    endtask

    task automatic t_dynamic();
        dreg_low_i = 64'h0000_1800_0000_0000;   // byte 5 = 0x18
        run(8'hFF, 1'b1, 1'b1, 1'b1, 3'd5, 0, -1, 0);
        chk(n_xfer == 2, "R2 dyn count", 96'(n_xfer), 96'd2);
        chk(log_idx[0] == 3'd4 && log_idx[1] == 3'd3, "R2 dyn regs", 96'({log_idx[0], log_idx[1]}), 96'({3'd4, 3'd3}));
        run(8'h40, 1'b1, 1'b1, 1'b0, 3'd5, 0, -1, 0);
        chk(n_xfer == 1 && log_idx[0] == 3'd6, "R2 static", 96'(log_idx[0]), 96'd6);
    endtask

    task automatic t_empty();
        run(8'h00, 1'b1, 1'b1, 1'b0, 3'd0, 0, -1, 0);
        chk(to_done == 1, "R7 done timing", 96'(to_done), 96'd1);
        chk(busy_cnt == 0 && n_req_end == 0, "R7 no activity", 96'(busy_cnt + n_req_end), 96'd0);
    endtask

    task automatic t_gaps();
        int b1;
        run(8'h81, 1'b1, 1'b0, 1'b0, 3'd0, 0, -1, 0);
        b1 = busy_cnt;
        run(8'hC0, 1'b1, 1'b0, 1'b0, 3'd0, 0, -1, 0);
        chk(b1 == busy_cnt && b1 == 4, "R6 gaps free", 96'(b1), 96'(busy_cnt));
    endtask

    task automatic t_fault();
        run(8'hF0, 1'b1, 1'b1, 1'b0, 3'd0, 0, 1, 0);
        chk(saw_fault, "R8 fault flag", 96'(saw_fault), 96'd1);
        chk(fidx == 3'd6, "R8 fault index", 96'(fidx), 96'd6);
        chk(n_xfer == 1 && n_req_end == 2, "R8 stop", 96'(n_req_end), 96'd2);
        repeat (3) @(negedge clk);
        chk(!mem_req_o && !busy_o && n_req_end == 2, "R8 no more requests", 96'(n_req_end), 96'd2);
    endtask

    task automatic t_restart();
        logic [2:0] e [4] = '{3'd3, 3'd2, 3'd1, 3'd0};
        run(8'h0F, 1'b1, 1'b1, 1'b0, 3'd0, 1, -1, 2);
        chk(n_xfer == 4, "R9 restart ignored", 96'(n_xfer), 96'd4);
        for (int i = 0; i < 4; i++)
            chk(log_idx[i] == e[i] && log_we[i], "R9 order kept", 96'(log_idx[i]), 96'(e[i]));
        chk(busy_cnt == 12, "R9 busy span", 96'(busy_cnt), 96'd12);
        chk(!busy_o, "R9 no relaunch", 96'(busy_o), 96'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_predec_store();
        t_postinc_store();
        t_load();
        t_dynamic();
        t_empty();
        t_gaps();
        t_fault();
        t_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule